// File: doc/BRIEF.md
# Oscillator Frequency Meter

This block measures the rate of one of four monitored clocks using a fixed reference clock. A controller programs a target number of monitored-clock cycles and a channel number, sets the free-running measurement clock enable, and then sets the measure enable. The meter counts reference cycles for as long as the selected clock needs to complete the programmed number of its own cycles. When the selected clock has finished, the meter sets a valid flag and the reference-cycle count appears in the result register. The result is inversely proportional to the monitored frequency: frequency = target × f_ref / result.

Each monitored clock has its own small cycle counter that runs in its own domain. The start request enters that domain through a two-flop synchronizer. The done indication returns to the reference domain through another two-flop synchronizer. A channel that has no running clock never reports done, so its result stays at zero. The channel number and the target count are frozen when a measurement starts, so later writes to them only take effect after the measure enable has been cleared and set again.

Top module: `fmeter_top`

## Requirements
- R1: After reset, the control register (offset 0x00), the result register (offset 0x0C) and the monitor register (offset 0x10) all read zero.
- R2: The control register reads back as written, with the target count in bits 23:0, the measure enable in bit 24 and the channel number in bits 27:26. Bit 8 of the monitor register (free-run enable) also reads back as written.
- R3: With free-run and measure enabled, monitor bit 0 (valid) eventually sets, and the result lies between N·Tmon/Tref − 2 and N·Tmon/Tref + 4·Tmon/Tref + 8. Here N is the target count, Tmon is the period of the selected clock and Tref is the reference period.
- R4: The channel field picks the clock that is measured: clocks with different periods give results in proportion to their periods.
- R5: While the measure enable stays set, the valid flag and the result hold steady after the measurement completes.
- R6: Clearing the measure enable clears the valid flag and returns the result to zero within four reference cycles, and this also applies to a measurement that is still running. A new measurement can follow.
- R7: Writes to the channel or target count while the measure enable is set do not affect the measurement in progress. The new values are used after the enable is cleared and set again.
- R8: While free-run is clear, setting the measure enable starts nothing: valid stays clear and the result stays zero. The measurement starts once free-run is set.
- R9: If the selected monitored clock is not running, valid never sets and the result stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register interface |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| monClk | input | NCHAN (4) | Monitored clocks, one per channel |
| regWrEn | input | 1 | Register write strobe, sampled on clk |
| regAddr | input | 5 | Byte offset of the register being accessed |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |

## Verification
Register writes take effect at the first clk edge after the strobe, and reads are combinational. The bench therefore samples read data one time unit after the falling edge in the same cycle it drives the address. The valid flag can only be predicted within a window, because the start request and the done indication each pass through two synchronizer flops. For that reason the bench polls the monitor register every cycle, up to a timeout derived from the expected count, and checks the result against a tolerance band rather than an exact value. After the enable is cleared, the cleared state follows a fixed two-edge path: first the enable register, then the controller state. The bench waits four cycles before it reads the cleared valid flag and result.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;
  parameter int CNT_W = 24;
  parameter int SEL_W = 2;

  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_RESULT = 5'h0C;
  localparam logic [4:0] OFS_MON    = 5'h10;

  localparam int EN_BIT      = 24;
  localparam int SEL_LSB     = 26;
  localparam int FREERUN_BIT = 8;
  localparam int VALID_BIT   = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_DRAIN = 2'd3
  } fmState_t;

  typedef struct packed {
    logic             clear;
    logic             countEn;
    logic             capture;
    logic             startReq;
    logic [SEL_W-1:0] chanSel;
    logic [CNT_W-1:0] target;
  } fmStrobe_t;
endpackage

// File: rtl/fmeter_sync.sv
module fmeter_sync (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fmeter_chan.sv
module fmeter_chan
  import fmeter_pkg::*;
(
  input  logic             monClk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] target,
  output logic             doneOut
);
  logic             startS;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  fmeter_sync u_startSync (
    .clk (monClk),
    .rstN(rstN),
    .d   (startReq),
    .q   (startS)
  );

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      doneOut <= 1'b0;
    end else if (!startS) begin
      cnt     <= '0;
      doneOut <= 1'b0;
    end else if (!doneOut) begin
      cnt <= cntNext;
      if (cntNext == target) doneOut <= 1'b1;
    end
  end

  // R3: completion can only be reported while a start request is seen
  p_done_after_start_r3: assert property (@(posedge monClk) disable iff (!rstN)
    $rose(doneOut) |-> startS)
    else $error("done rose without start");
endmodule

// File: rtl/fmeter_datapath.sv
module fmeter_datapath
  import fmeter_pkg::*;
#(
  parameter int NCHAN = 4,
  parameter int REF_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCHAN-1:0] monClk,
  input  fmStrobe_t        strobe,
  output logic             doneSeen,
  output logic [REF_W-1:0] result
);
  logic [NCHAN-1:0] startVec;
  logic [NCHAN-1:0] doneRaw;
  logic [NCHAN-1:0] doneSyncd;
  logic [REF_W-1:0] refCnt;

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    assign startVec[g] = strobe.startReq && (strobe.chanSel == SEL_W'(g));

    fmeter_chan u_chan (
      .monClk  (monClk[g]),
      .rstN    (rstN),
      .startReq(startVec[g]),
      .target  (strobe.target),
      .doneOut (doneRaw[g])
    );

    fmeter_sync u_doneSync (
      .clk (clk),
      .rstN(rstN),
      .d   (doneRaw[g]),
      .q   (doneSyncd[g])
    );
  end

  always_comb begin
    doneSeen = 1'b0;
    for (int i = 0; i < NCHAN; i++) begin
      if (strobe.chanSel == SEL_W'(i)) doneSeen = doneSyncd[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (strobe.clear) begin
      refCnt <= '0;
    end else if (strobe.countEn && !(&refCnt)) begin
      refCnt <= refCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.clear) begin
      result <= '0;
    end else if (strobe.capture) begin
      result <= refCnt;
    end
  end

  // R3: the reference counter saturates instead of wrapping
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&refCnt && !strobe.clear) |=> &refCnt)
    else $error("reference counter wrapped");

  // R6: a clear request leaves the result at zero
  p_result_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (result == '0))
    else $error("result not cleared");
endmodule

// File: rtl/fmeter_ctrl.sv
module fmeter_ctrl
  import fmeter_pkg::*;
#(
  parameter int REF_W     = 32,
  parameter int DRAIN_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [4:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [REF_W-1:0] result,
  input  logic             doneSeen,
  output fmStrobe_t        strobe
);
  localparam int DW = $clog2(DRAIN_CYC + 1);

  logic [CNT_W-1:0] ctlCount;
  logic             ctlEn;
  logic [SEL_W-1:0] ctlChan;
  logic             freeRun;
  fmState_t         state;
  logic [CNT_W-1:0] activeTarget;
  logic [SEL_W-1:0] activeChan;
  logic [DW-1:0]    drainCnt;
  logic             measValid;
  logic             unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:28], regWrData[25]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlCount <= '0;
      ctlEn    <= 1'b0;
      ctlChan  <= '0;
      freeRun  <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == OFS_CTRL) begin
        ctlCount <= regWrData[CNT_W-1:0];
        ctlEn    <= regWrData[EN_BIT];
        ctlChan  <= regWrData[SEL_LSB +: SEL_W];
      end
      if (regAddr == OFS_MON) freeRun <= regWrData[FREERUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      activeTarget <= '0;
      activeChan   <= '0;
      drainCnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          drainCnt <= '0;
          if (ctlEn && freeRun && !doneSeen) begin
            state        <= ST_RUN;
            activeTarget <= ctlCount;
            activeChan   <= ctlChan;
          end
        end
        ST_RUN: begin
          if (!ctlEn)        state <= ST_DRAIN;
          else if (doneSeen) state <= ST_DONE;
        end
        ST_DONE: begin
          if (!ctlEn) state <= ST_DRAIN;
        end
        default: begin
          if (doneSeen)                           drainCnt <= '0;
          else if (drainCnt == DW'(DRAIN_CYC - 1)) state   <= ST_IDLE;
          else                                    drainCnt <= drainCnt + 1'b1;
        end
      endcase
    end
  end

  assign measValid = (state == ST_DONE);

  always_comb begin
    strobe          = '0;
    strobe.clear    = (state == ST_IDLE) || (state == ST_DRAIN);
    strobe.countEn  = (state == ST_RUN) && freeRun;
    strobe.capture  = (state == ST_RUN) && ctlEn && doneSeen;
    strobe.startReq = (state == ST_RUN) || (state == ST_DONE);
    strobe.chanSel  = activeChan;
    strobe.target   = activeTarget;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdData[CNT_W-1:0]         = ctlCount;
        regRdData[EN_BIT]            = ctlEn;
        regRdData[SEL_LSB +: SEL_W]  = ctlChan;
      end
      OFS_RESULT: regRdData = 32'(result);
      OFS_MON: begin
        regRdData[FREERUN_BIT] = freeRun;
        regRdData[VALID_BIT]   = measValid;
      end
      default: regRdData = '0;
    endcase
  end

  // R6: valid cannot outlive a cleared enable by more than one edge
  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEn |=> (state != ST_DONE))
    else $error("valid held after enable cleared");

  // R8: no measurement starts without the free-running clock
  p_start_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !freeRun) |=> (state != ST_RUN))
    else $error("started without free-run");

  // R7: latched configuration is frozen during a run
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> ($stable(activeTarget) && $stable(activeChan)))
    else $error("configuration changed mid-run");
endmodule

// File: rtl/fmeter_top.sv
module fmeter_top
  import fmeter_pkg::*;
#(
  parameter int NCHAN     = 4,
  parameter int REF_W     = 32,
  parameter int DRAIN_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCHAN-1:0] monClk,
  input  logic             regWrEn,
  input  logic [4:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData
);
  fmStrobe_t        strobe;
  logic             doneSeen;
  logic [REF_W-1:0] result;

  fmeter_ctrl #(
    .REF_W    (REF_W),
    .DRAIN_CYC(DRAIN_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .result   (result),
    .doneSeen (doneSeen),
    .strobe   (strobe)
  );

  fmeter_datapath #(
    .NCHAN(NCHAN),
    .REF_W(REF_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .monClk  (monClk),
    .strobe  (strobe),
    .doneSeen(doneSeen),
    .result  (result)
  );
endmodule

// File: tb/fmeter_top_tb.sv
`timescale 1ns/1ps
module fmeter_top_tb;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_RES  = 5'h0C;
  localparam logic [4:0] A_MON  = 5'h10;
  localparam real TREF = 20.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        m0 = 1'b0, m1 = 1'b0, m2 = 1'b0, m3 = 1'b0;
  logic        ch3On = 1'b1;
  logic [3:0]  monClk;
  int          vectors = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;
  always #4  m0 = ~m0;
  always #7  m1 = ~m1;
  always #23 m2 = ~m2;
  always begin
    #13;
    if (ch3On) m3 = ~m3;
    else       m3 = 1'b0;
  end
  assign monClk = {m3, m2, m1, m0};

  fmeter_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .monClk   (monClk),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );

  function automatic real tmonOf(input int ch);
    case (ch)
      0: return 8.0;
      1: return 14.0;
      2: return 46.0;
      default: return 26.0;
    endcase
  endfunction

  function automatic logic [31:0] ctrlWord(input int ch, input bit en, input int n);
    ctrlWord = '0;
    ctrlWord[23:0] = 24'(n);
    ctrlWord[24] = en;
    ctrlWord[27:26] = 2'(ch);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chkRange(input string req, input logic [31:0] got, input int lo, input int hi);
    vectors++;
    if ($signed(got) < lo || $signed(got) > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pollValid(input int limit, output bit seen);
    logic [31:0] d;
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      regRead(A_MON, d);
      if (d[0]) begin seen = 1'b1; break; end
    end
  endtask

  task automatic checkResult(input string req, input int ch, input int n);
    logic [31:0] d;
    bit seen;
    real e, tm;
    tm = tmonOf(ch);
    e = n * tm / TREF;
    pollValid($rtoi(e) + 200, seen);
    chk({req, " valid"}, 32'(seen), 32'd1);
    regRead(A_RES, d);
    chkRange({req, " result"}, d, $rtoi(e) - 2, $rtoi(e + 4.0 * tm / TREF) + 8);
  endtask

  task automatic clearAndCheck(input string req, input logic [31:0] keep);
    logic [31:0] d;
    regWrite(A_CTRL, keep);
    waitCyc(4);
    regRead(A_MON, d);
    chk({req, " valid cleared"}, 32'(d[0]), 32'd0);
    regRead(A_RES, d);
    chk({req, " result cleared"}, d, 32'd0);
    waitCyc(12);
  endtask

  initial begin
    #(20.0 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r1;
    bit seen;
    int seedDummy;
    seedDummy = $urandom(32'd13579);
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    regRead(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
    regRead(A_RES, d);  chk("R1 result", d, 32'd0);
    regRead(A_MON, d);  chk("R1 monitor", d, 32'd0);

    // R2 readback with enable clear
    regWrite(A_CTRL, ctrlWord(2, 1'b0, 24'h00ABCD));
    regRead(A_CTRL, d); chk("R2 ctrl fields", d, 32'h0800ABCD);
    regWrite(A_MON, 32'h100);
    regRead(A_MON, d); chk("R2 free-run bit", d, 32'h100);

    // R8 no start without free-run
    regWrite(A_MON, 32'h0);
    regWrite(A_CTRL, ctrlWord(0, 1'b1, 64));
    waitCyc(100);
    regRead(A_MON, d); chk("R8 valid stays clear", 32'(d[0]), 32'd0);
    regRead(A_RES, d); chk("R8 result stays zero", d, 32'd0);
    regWrite(A_MON, 32'h100);
    checkResult("R8 start after free-run", 0, 64);
    clearAndCheck("R6", 32'd0);

    // R4 each channel, same count
    for (int ch = 0; ch < 4; ch++) begin
      regWrite(A_CTRL, ctrlWord(ch, 1'b1, 200));
      checkResult("R4 channel", ch, 200);
      clearAndCheck("R6", 32'd0);
    end

    // R5 hold while enabled
    regWrite(A_CTRL, ctrlWord(1, 1'b1, 500));
    checkResult("R5 first", 1, 500);
    regRead(A_RES, r1);
    waitCyc(50);
    regRead(A_RES, d); chk("R5 result held", d, r1);
    regRead(A_MON, d); chk("R5 valid held", 32'(d[0]), 32'd1);
    clearAndCheck("R6", 32'd0);

    // R7 changes while enabled are ignored
    regWrite(A_CTRL, ctrlWord(0, 1'b1, 100));
    regWrite(A_CTRL, ctrlWord(2, 1'b1, 900));
    checkResult("R7 old config used", 0, 100);
    clearAndCheck("R6", ctrlWord(2, 1'b0, 900));
    regWrite(A_CTRL, ctrlWord(2, 1'b1, 900));
    checkResult("R7 new config after re-enable", 2, 900);
    clearAndCheck("R6", 32'd0);

    // R6 abort mid-run, then restart
    regWrite(A_CTRL, ctrlWord(2, 1'b1, 1000));
    waitCyc(100);
    clearAndCheck("R6 abort", 32'd0);
    regWrite(A_CTRL, ctrlWord(1, 1'b1, 300));
    checkResult("R6 restart", 1, 300);
    clearAndCheck("R6", 32'd0);

    // R9 absent clock
    ch3On = 1'b0;
    waitCyc(10);
    regWrite(A_CTRL, ctrlWord(3, 1'b1, 50));
    pollValid(400, seen);
    chk("R9 valid never", 32'(seen), 32'd0);
    regRead(A_RES, d); chk("R9 result zero", d, 32'd0);
    clearAndCheck("R6", 32'd0);
    ch3On = 1'b1;
    waitCyc(10);

    // R3 random measurements
    for (int k = 0; k < 10; k++) begin
      int ch, n;
      ch = int'($urandom % 4);
      n = 16 + int'($urandom % 1009);
      regWrite(A_CTRL, ctrlWord(ch, 1'b1, n));
      checkResult("R3 random", ch, n);
      clearAndCheck("R6", 32'd0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule